// File: doc/BRIEF.md
# Debug Watchpoint Match Unit

This block is a single watchpoint comparator for a processor debug subsystem. It looks at every qualified bus cycle and checks three fields: the address, the data and an eight-bit control attribute vector. The control vector covers transfer direction, transfer size, the two protection bits, an external debug line, a chain line from a partner unit and a range line from a partner unit. Each field has a programmable value register and a mask register laid out the same way. A mask bit of 1 turns that bit position into a don't-care, so it always agrees. A mask bit of 0 requires the bus bit to equal the value bit. A separate enable bit, held above the maskable control bits, gates the whole unit.

Software or a debug controller programs the six registers through a plain write port that selects a register with a 3-bit code. The unit gives two results. `chain_o` is the combinational hit of the current cycle, so a partner unit can take it as its chain input in the same cycle. `match_o` is the registered result and is high for one clock after each qualified cycle that hit.

A three-state sequencer drives `match_o`. DISARMED is the state while the enable bit is 0. ARMED means the unit is enabled and the previous cycle did not hit. HIT means the previous qualified cycle hit. The transitions are named as follows. `arm`: DISARMED to ARMED when the enable bit is 1. `fire`: ARMED or HIT to HIT when the cycle is valid and every field agrees. `rearm`: HIT to ARMED when it does not. `disarm`: any state to DISARMED when the enable bit is 0. `match_o` is high exactly in HIT.

Top module: `wp_match_unit`

## Requirements
- R1: After reset every register holds 0, and `match_o` and `chain_o` are 0 whatever the bus inputs carry, so the unit is disabled.
- R2: Each address bit agrees when its address mask bit is 1, or when `bus_addr` equals the address value bit.
- R3: Each data bit agrees under the same rule using the data value and data mask. A data mask of all ones makes `bus_data` irrelevant to the result.
- R4: The control input vector is bit 0 = `bus_write` (0 read, 1 write), bits 2:1 = `bus_size` (00 byte, 01 halfword, 10 word, 11 reserved), bit 3 = `bus_prot[0]` (0 fetch, 1 data), bit 4 = `bus_prot[1]` (0 user, 1 privileged), bit 5 = `dbg_ext_i`, bit 6 = `chain_in`, bit 7 = `range_in`. It is compared bitwise with control value bits 7:0 under control mask bits 7:0.
- R5: Control value bit 8 is the enable bit and has no mask. While it is 0 no hit or match is ever signalled. Bit 8 of a control mask write is discarded.
- R6: `match_o` is 1 in the clock after a cycle with `bus_valid`=1, the enable bit set, and all three fields agreeing, and 0 otherwise. Cycles with `bus_valid`=0 never produce a match.
- R7: `chain_o` equals, in the same cycle, the enable bit AND `bus_valid` AND agreement of all three fields.
- R8: With `wr_en`=1, `wr_sel` chooses the register written at the next clock: 0 address value, 1 address mask, 2 data value, 3 data mask, 4 control value (9 bits), 5 control mask (8 bits). Codes 6 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select code |
| wr_data | input | max(AW,DW,9) | Write data, low bits used per register |
| bus_valid | input | 1 | Qualifies the current bus cycle |
| bus_addr | input | AW | Bus address |
| bus_data | input | DW | Bus data |
| bus_write | input | 1 | Direction, 1 = write |
| bus_size | input | 2 | Transfer size code |
| bus_prot | input | 2 | Protection bits |
| dbg_ext_i | input | 1 | External debug condition |
| chain_in | input | 1 | Hit from the paired unit |
| range_in | input | 1 | Range condition from the paired unit |
| chain_o | output | 1 | Combinational hit of this cycle |
| match_o | output | 1 | Registered match |

## Verification
The bench builds the unit with AW=8 and DW=8. At that width every address and every data pattern can be swept against a chosen value and mask, and every one of the 256 control input vectors can be swept against several value and mask pairs. This puts each bit's mask rule, the size and protection encodings, the enable gating and the one-cycle registration within full reach. It also covers the unused select codes and the discarded mask bit 8.

// File: rtl/wp_pkg.sv
package wp_pkg;

    // Control field bit positions (compared vector, bits 7:0) and enable.
    localparam int CB_WRITE  = 0;
    localparam int CB_SIZE_LO = 1;
    localparam int CB_SIZE_HI = 2;
    localparam int CB_PROT0  = 3;
    localparam int CB_PROT1  = 4;
    localparam int CB_DBG    = 5;
    localparam int CB_CHAIN  = 6;
    localparam int CB_RANGE  = 7;
    localparam int CB_ENABLE = 8;

    localparam int CTRL_CMP_W = 8;
    localparam int CTRL_VAL_W = 9;
    localparam int SEL_W      = 3;

    typedef enum logic [SEL_W-1:0] {
        SEL_ADDR_VAL = 3'd0,
        SEL_ADDR_MSK = 3'd1,
        SEL_DATA_VAL = 3'd2,
        SEL_DATA_MSK = 3'd3,
        SEL_CTRL_VAL = 3'd4,
        SEL_CTRL_MSK = 3'd5,
        SEL_SPARE6   = 3'd6,
        SEL_SPARE7   = 3'd7
    } reg_sel_e;

    typedef enum logic [1:0] {
        ST_DISARMED = 2'd0,
        ST_ARMED    = 2'd1,
        ST_HIT      = 2'd2
    } wp_state_e;

endpackage

// File: rtl/wp_regs.sv
module wp_regs
    import wp_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int WW = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [SEL_W-1:0]      wr_sel,
    input  logic [WW-1:0]         wr_data,
    output logic [AW-1:0]         addr_val,
    output logic [AW-1:0]         addr_msk,
    output logic [DW-1:0]         data_val,
    output logic [DW-1:0]         data_msk,
    output logic [CTRL_VAL_W-1:0] ctrl_val,
    output logic [CTRL_CMP_W-1:0] ctrl_msk
);

    reg_sel_e sel;
    assign sel = reg_sel_e'(wr_sel);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_val <= '0;
            addr_msk <= '0;
            data_val <= '0;
            data_msk <= '0;
            ctrl_val <= '0;
            ctrl_msk <= '0;
        end else if (wr_en) begin
            unique case (sel)
                SEL_ADDR_VAL: addr_val <= wr_data[AW-1:0];
                SEL_ADDR_MSK: addr_msk <= wr_data[AW-1:0];
                SEL_DATA_VAL: data_val <= wr_data[DW-1:0];
                SEL_DATA_MSK: data_msk <= wr_data[DW-1:0];
                SEL_CTRL_VAL: ctrl_val <= wr_data[CTRL_VAL_W-1:0];
                SEL_CTRL_MSK: ctrl_msk <= wr_data[CTRL_CMP_W-1:0];
                SEL_SPARE6, SEL_SPARE7: begin
                end
            endcase
        end
    end

endmodule

// File: rtl/wp_masked_cmp.sv
module wp_masked_cmp #(
    parameter int W = 32
) (
    input  logic [W-1:0] value,
    input  logic [W-1:0] mask,
    input  logic [W-1:0] probe,
    output logic         agree
);

    logic [W-1:0] bit_ok;

    // A set mask bit forces agreement; a clear one demands equality.
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign bit_ok[i] = mask[i] | ~(value[i] ^ probe[i]);
    end

    assign agree = &bit_ok;

endmodule

// File: rtl/wp_seq.sv
module wp_seq
    import wp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic qualified_hit,
    output logic match_o
);

    wp_state_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_DISARMED;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_DISARMED: begin
                if (enable) state_nx = qualified_hit ? ST_HIT : ST_ARMED; // arm / fire
            end
            ST_ARMED: begin
                if (!enable)           state_nx = ST_DISARMED;        // disarm
                else if (qualified_hit) state_nx = ST_HIT;            // fire
            end
            ST_HIT: begin
                if (!enable)            state_nx = ST_DISARMED;       // disarm
                else if (!qualified_hit) state_nx = ST_ARMED;         // rearm
            end
            default: state_nx = ST_DISARMED;
        endcase
    end

    always_comb begin
        unique case (state)
            ST_HIT:  match_o = 1'b1;
            default: match_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/wp_match_unit.sv
module wp_match_unit
    import wp_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    localparam int WW0 = (AW > DW) ? AW : DW,
    localparam int WW = (WW0 > CTRL_VAL_W) ? WW0 : CTRL_VAL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [WW-1:0]    wr_data,
    input  logic             bus_valid,
    input  logic [AW-1:0]    bus_addr,
    input  logic [DW-1:0]    bus_data,
    input  logic             bus_write,
    input  logic [1:0]       bus_size,
    input  logic [1:0]       bus_prot,
    input  logic             dbg_ext_i,
    input  logic             chain_in,
    input  logic             range_in,
    output logic             chain_o,
    output logic             match_o
);

    logic [AW-1:0]         addr_val, addr_msk;
    logic [DW-1:0]         data_val, data_msk;
    logic [CTRL_VAL_W-1:0] ctrl_val;
    logic [CTRL_CMP_W-1:0] ctrl_msk;
    logic [CTRL_CMP_W-1:0] ctrl_probe;
    logic                  addr_ok, data_ok, ctrl_ok;
    logic                  ctrl_enable;
    logic                  hit_now;

    wp_regs #(.AW(AW), .DW(DW), .WW(WW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .addr_val(addr_val), .addr_msk(addr_msk),
        .data_val(data_val), .data_msk(data_msk),
        .ctrl_val(ctrl_val), .ctrl_msk(ctrl_msk)
    );

    always_comb begin
        ctrl_probe                       = '0;
        ctrl_probe[CB_WRITE]             = bus_write;
        ctrl_probe[CB_SIZE_HI:CB_SIZE_LO] = bus_size;
        ctrl_probe[CB_PROT0]             = bus_prot[0];
        ctrl_probe[CB_PROT1]             = bus_prot[1];
        ctrl_probe[CB_DBG]               = dbg_ext_i;
        ctrl_probe[CB_CHAIN]             = chain_in;
        ctrl_probe[CB_RANGE]             = range_in;
    end

    wp_masked_cmp #(.W(AW)) u_cmp_addr (
        .value(addr_val), .mask(addr_msk), .probe(bus_addr), .agree(addr_ok)
    );
    wp_masked_cmp #(.W(DW)) u_cmp_data (
        .value(data_val), .mask(data_msk), .probe(bus_data), .agree(data_ok)
    );
    wp_masked_cmp #(.W(CTRL_CMP_W)) u_cmp_ctrl (
        .value(ctrl_val[CTRL_CMP_W-1:0]), .mask(ctrl_msk),
        .probe(ctrl_probe), .agree(ctrl_ok)
    );

    assign ctrl_enable = ctrl_val[CB_ENABLE];
    assign hit_now     = ctrl_enable & bus_valid & addr_ok & data_ok & ctrl_ok;
    assign chain_o     = hit_now;

    wp_seq u_seq (
        .clk(clk), .rst_n(rst_n),
        .enable(ctrl_enable), .qualified_hit(hit_now),
        .match_o(match_o)
    );

endmodule

// File: rtl/wp_match_checker.sv
module wp_match_checker (
    input logic clk,
    input logic rst_n,
    input logic bus_valid,
    input logic enable,
    input logic chain_o,
    input logic match_o
);

    // R1: the first cycle out of reset shows no match
    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !match_o);

    // R5: a disabled unit never matches in the following cycle
    a_r5_enable_gates: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !match_o);

    // R6: idle cycles never produce a match
    a_r6_idle_no_match: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_valid |=> !match_o);

    // R6: registered result follows the same-cycle hit by one clock
    a_r6_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (match_o == $past(chain_o)));

    // R7: a same-cycle hit requires a valid cycle and the enable bit
    a_r7_chain_qualified: assert property (@(posedge clk) disable iff (!rst_n)
        chain_o |-> (bus_valid && enable));

endmodule

bind wp_match_unit wp_match_checker u_chk (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid),
    .enable(ctrl_enable), .chain_o(chain_o), .match_o(match_o)
);

// File: tb/tb_wp_match_unit.sv
`timescale 1ns/1ps
module tb_wp_match_unit;
    localparam int AW = 8;
    localparam int DW = 8;
    localparam int WW = 9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [2:0]    wr_sel = '0;
    logic [WW-1:0] wr_data = '0;
    logic          bus_valid = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_data = '0;
    logic          bus_write = 1'b0;
    logic [1:0]    bus_size = '0;
    logic [1:0]    bus_prot = '0;
    logic          dbg_ext_i = 1'b0;
    logic          chain_in = 1'b0;
    logic          range_in = 1'b0;
    logic          chain_o, match_o;

    int checks = 0;
    int fails  = 0;

    // shadow of programmed registers
    logic [7:0] s_av = 0, s_am = 0, s_dv = 0, s_dm = 0, s_cm = 0;
    logic [8:0] s_cv = 0;

    always #4 clk = ~clk;

    wp_match_unit #(.AW(AW), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_data(bus_data),
        .bus_write(bus_write), .bus_size(bus_size), .bus_prot(bus_prot),
        .dbg_ext_i(dbg_ext_i), .chain_in(chain_in), .range_in(range_in),
        .chain_o(chain_o), .match_o(match_o)
    );

    task automatic chk(input logic got, input logic exp, input string tag);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got %0b exp %0b", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [8:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        case (sel)
            3'd0: s_av = d[7:0];
            3'd1: s_am = d[7:0];
            3'd2: s_dv = d[7:0];
            3'd3: s_dm = d[7:0];
            3'd4: s_cv = d;
            3'd5: s_cm = d[7:0];
            default: ;
        endcase
    endtask

    function automatic logic expect_hit(input logic v, input logic [7:0] a,
                                        input logic [7:0] d, input logic [7:0] c);
        return s_cv[8] & v & (((a ^ s_av) & ~s_am) == 8'h00)
                           & (((d ^ s_dv) & ~s_dm) == 8'h00)
                           & (((c ^ s_cv[7:0]) & ~s_cm) == 8'h00);
    endfunction

    // Control vector: 0 write, 2:1 size, 3 prot0, 4 prot1, 5 dbg, 6 chain, 7 range
    task automatic probe(input logic v, input logic [7:0] a, input logic [7:0] d,
                         input logic [7:0] c, input string tag);
        logic e;
        @(negedge clk);
        bus_valid = v; bus_addr = a; bus_data = d;
        bus_write = c[0]; bus_size = c[2:1]; bus_prot = {c[4], c[3]};
        dbg_ext_i = c[5]; chain_in = c[6]; range_in = c[7];
        e = expect_hit(v, a, d, c);
        #1 chk(chain_o, e, {tag, " R7 chain_o"});
        @(negedge clk);
        chk(match_o, e, {tag, " match_o"});
        bus_valid = 1'b0;
    endtask

    task automatic ctrl_sweep(input logic [7:0] cv, input logic [7:0] cm);
        wr(3'd4, {1'b1, cv});
        wr(3'd5, {1'b0, cm});
        for (int c = 0; c < 256; c++) probe(1'b1, 8'h00, 8'h00, c[7:0], "R4 ctrl sweep");
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog expired got running exp done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(match_o, 1'b0, "R1 match in reset");
        chk(chain_o, 1'b0, "R1 chain in reset");
        rst_n = 1'b1;
        // R1: registers zero, so enable is 0: nothing matches
        probe(1'b1, 8'h00, 8'h00, 8'h00, "R1 after reset");
        probe(1'b1, 8'hFF, 8'hFF, 8'hFF, "R1 after reset ones");

        // R2: exact address, data ignored (R3)
        wr(3'd0, 9'h05A); wr(3'd1, 9'h000);
        wr(3'd3, 9'h0FF); wr(3'd5, 9'h0FF); wr(3'd4, 9'h100);
        for (int a = 0; a < 256; a++) probe(1'b1, a[7:0], 8'(a * 37), 8'(a), "R2 R3 addr exact");
        // R2: partially masked address
        wr(3'd1, 9'h00F);
        for (int a = 0; a < 256; a++) probe(1'b1, a[7:0], 8'h00, 8'h00, "R2 addr masked");

        // R3: data compare with partial mask
        wr(3'd1, 9'h0FF); wr(3'd2, 9'h0C3); wr(3'd3, 9'h030);
        for (int d = 0; d < 256; d++) probe(1'b1, 8'h77, d[7:0], 8'h00, "R3 data masked");
        wr(3'd3, 9'h0FF);

        // R4: control sweeps
        ctrl_sweep(8'h01, 8'hFE);   // write cycles only
        ctrl_sweep(8'h04, 8'hF9);   // word size
        ctrl_sweep(8'h18, 8'hE7);   // privileged data access
        ctrl_sweep(8'h60, 8'h9F);   // external and chain
        ctrl_sweep(8'h80, 8'h7F);   // range
        ctrl_sweep(8'hA5, 8'h00);   // fully specified

        // R5: enable clear; mask bit 8 discarded
        wr(3'd4, 9'h000); wr(3'd5, 9'h1FF);
        for (int c = 0; c < 256; c += 17) probe(1'b1, 8'h00, 8'h00, c[7:0], "R5 disabled");

        // R6: idle cycle after a hit
        wr(3'd4, 9'h100);
        probe(1'b1, 8'h12, 8'h34, 8'h00, "R6 hit");
        probe(1'b0, 8'h12, 8'h34, 8'h00, "R6 idle");

        // R8: spare select codes change nothing
        wr(3'd0, 9'h011); wr(3'd1, 9'h000); wr(3'd2, 9'h022); wr(3'd3, 9'h000);
        probe(1'b1, 8'h11, 8'h22, 8'h00, "R8 before spare");
        wr(3'd6, 9'h0EE); wr(3'd7, 9'h0EE);
        probe(1'b1, 8'h11, 8'h22, 8'h00, "R8 after spare");
        probe(1'b1, 8'hEE, 8'hEE, 8'h00, "R8 spare no addr/data");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule